// File: doc/BRIEF.md
# Sampling-Based Flow Size Classifier

This block sorts arriving packets into two logical priority queues without ever measuring how long a flow is. Each packet descriptor arrives with a flow identifier. For every arrival the block draws a pseudo-random coin with a small, programmable chance of heads. A flow whose packets have drawn enough heads is presumed long. It is recorded in a small associative table of sampled flows, and that packet and every later packet of the flow are steered to the low-priority queue. Flows that have not been sampled are presumed short and go to the high-priority queue. Most short flows finish before they draw a head, while long flows are caught with near certainty.

Two sampling modes are offered. In the basic mode a single head marks a flow as long. In the stricter mode, meant for a larger heads probability, the first head only marks the flow as pending and a second head is needed. Both queues live in one descriptor store, with a separate occupancy limit for each queue. Arrivals that find their queue full are dropped and counted. The high-priority queue is always served first.

Top module: `sift_classifier`

## Requirements
- R1: After reset both queues are empty (`out_valid` low), both drop counters read zero, `cls_valid` is low and the sampled-flow table holds no flows.
- R2: The coin shows heads when the internal LFSR value (1 to 2^LFSR_W-1) is below `coin_thresh`. A value of 0 never gives heads and 2^LFSR_W always does. An arrival that draws tails and belongs to no sampled flow is classified high priority (`cls_low`=0).
- R3: In basic mode (`strict_mode`=0), an arrival of an unrecorded flow that draws heads is classified low priority, and its flow is recorded as sampled.
- R4: An arrival whose flow is already recorded as sampled is classified low priority whatever the coin and the mode. The table lookup takes precedence over the coin.
- R5: In strict mode (`strict_mode`=1), the first head of an unrecorded flow only records the flow as pending, and the packet stays high priority. The packet that draws the flow's second head, and every later one, is low priority.
- R6: A pending flow whose arrival draws tails stays high priority and stays pending.
- R7: While the high-priority queue holds an entry, the output presents it (`out_lowprio`=0) ahead of any low-priority entry.
- R8: Within each queue, descriptors leave in arrival order. An entry is removed at a clock edge where `out_ready` and `out_valid` are both high.
- R9: An arrival that finds its queue at its limit (HI_CAP for high, LO_CAP for low) is not stored. `cls_drop` is set and that queue's drop counter increments, saturating at its maximum. The other queue and its counter are unaffected.
- R10: A head that must record a new flow uses the lowest free table slot. When all TBL_DEPTH slots are in use, it replaces slots in round-robin order starting at slot 0, and the flow held in the replaced slot is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode | input | 1 | 0: one head samples a flow; 1: two heads needed |
| coin_thresh | input | LFSR_W+1 | Heads when LFSR value is below this |
| in_valid | input | 1 | Arrival strobe |
| in_flow | input | FLOW_W | Flow identifier of the arrival |
| in_desc | input | DESC_W | Packet descriptor of the arrival |
| cls_valid | output | 1 | Classification result valid, one cycle after arrival |
| cls_low | output | 1 | Arrival was steered to the low-priority queue |
| cls_drop | output | 1 | Arrival was dropped because its queue was full |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_valid | output | 1 | An entry is presented |
| out_lowprio | output | 1 | Presented entry comes from the low-priority queue |
| out_flow | output | FLOW_W | Flow identifier of the presented entry |
| out_desc | output | DESC_W | Descriptor of the presented entry |
| drop_hi | output | DROP_W | Drops of high-priority arrivals |
| drop_lo | output | DROP_W | Drops of low-priority arrivals |

## Verification
An arrival is sampled at one rising edge. Its classification flags, the drop counter update and the stored entry are all visible after that same edge. A removal takes effect at the edge where `out_ready` is seen high. The bench drives inputs on the falling edge, holds an arrival for exactly one rising edge, and reads the flags and counters at the following falling edge, before the next edge can replace them. For dequeue checks it reads the presented entry at a falling edge, then raises `out_ready` across one rising edge. Coin outcomes are forced with the two extreme thresholds, so each expected classification follows from the requirements alone.

// File: rtl/sift_classifier.sv
module sift_classifier #(
  parameter int FLOW_W     = 16,
  parameter int DESC_W     = 8,
  parameter int LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int TBL_DEPTH  = 8,
  parameter int HI_CAP     = 4,
  parameter int LO_CAP     = 12,
  parameter int DROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strict_mode,
  input  logic [LFSR_W:0]   coin_thresh,
  input  logic              in_valid,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [DESC_W-1:0] in_desc,
  output logic              cls_valid,
  output logic              cls_low,
  output logic              cls_drop,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_lowprio,
  output logic [FLOW_W-1:0] out_flow,
  output logic [DESC_W-1:0] out_desc,
  output logic [DROP_W-1:0] drop_hi,
  output logic [DROP_W-1:0] drop_lo
);
  localparam int BUF_DEPTH = HI_CAP + LO_CAP;
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam int TW = $clog2(TBL_DEPTH);

  logic [LFSR_W-1:0] lfsr;
  logic              heads;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= LFSR_SEED;
    else if (in_valid) lfsr <= lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS) : (lfsr >> 1);
  end

  assign heads = {1'b0, lfsr} < coin_thresh;

  logic [TBL_DEPTH-1:0] tv, ts;
  logic [FLOW_W-1:0]    tid [TBL_DEPTH];
  logic [TW-1:0]        rr_ptr, hit_idx, free_idx, ins_idx;
  logic                 hit_any, free_any, hit_sampled;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
      if (tv[i] && tid[i] == in_flow) begin
        hit_any = 1'b1;
        hit_idx = TW'(i);
      end
      if (!tv[i]) begin
        free_any = 1'b1;
        free_idx = TW'(i);
      end
    end
  end

  assign hit_sampled = hit_any && ts[hit_idx];
  assign ins_idx     = free_any ? free_idx : rr_ptr;

  logic to_low, record;
  assign to_low = hit_sampled || (heads && (!strict_mode || hit_any));
  assign record = in_valid && heads && !hit_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      tv     <= '0;
      ts     <= '0;
      rr_ptr <= '0;
    end else if (in_valid && heads) begin
      if (hit_any) begin
        ts[hit_idx] <= 1'b1;
      end else begin
        tv[ins_idx] <= 1'b1;
        ts[ins_idx] <= !strict_mode;
        if (!free_any)
          rr_ptr <= (rr_ptr == TW'(TBL_DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (record) tid[ins_idx] <= in_flow;
  end

  logic [FLOW_W-1:0] mem_flow [BUF_DEPTH];
  logic [DESC_W-1:0] mem_desc [BUF_DEPTH];
  logic [AW-1:0]     hi_wr, hi_rd, lo_wr, lo_rd, wr_addr, rd_addr;
  logic [CW-1:0]     hi_cnt, lo_cnt;
  logic              accept, push_hi, push_lo, pop_hi, pop_lo;

  assign accept  = in_valid && (to_low ? (lo_cnt != CW'(LO_CAP)) : (hi_cnt != CW'(HI_CAP)));
  assign push_hi = accept && !to_low;
  assign push_lo = accept && to_low;
  assign pop_hi  = out_ready && (hi_cnt != '0);
  assign pop_lo  = out_ready && (hi_cnt == '0) && (lo_cnt != '0);
  assign wr_addr = to_low ? (AW'(HI_CAP) + lo_wr) : hi_wr;
  assign rd_addr = (hi_cnt != '0) ? hi_rd : (AW'(HI_CAP) + lo_rd);

  always_ff @(posedge clk) begin
    if (accept) begin
      mem_flow[wr_addr] <= in_flow;
      mem_desc[wr_addr] <= in_desc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_wr  <= '0;
      hi_rd  <= '0;
      lo_wr  <= '0;
      lo_rd  <= '0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (push_hi) hi_wr <= (hi_wr == AW'(HI_CAP - 1)) ? '0 : hi_wr + 1'b1;
      if (push_lo) lo_wr <= (lo_wr == AW'(LO_CAP - 1)) ? '0 : lo_wr + 1'b1;
      if (pop_hi)  hi_rd <= (hi_rd == AW'(HI_CAP - 1)) ? '0 : hi_rd + 1'b1;
      if (pop_lo)  lo_rd <= (lo_rd == AW'(LO_CAP - 1)) ? '0 : lo_rd + 1'b1;
      hi_cnt <= hi_cnt + CW'(push_hi) - CW'(pop_hi);
      lo_cnt <= lo_cnt + CW'(push_lo) - CW'(pop_lo);
    end
  end

  assign out_valid   = (hi_cnt != '0) || (lo_cnt != '0);
  assign out_lowprio = (hi_cnt == '0);
  assign out_flow    = mem_flow[rd_addr];
  assign out_desc    = mem_desc[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid <= 1'b0;
      cls_low   <= 1'b0;
      cls_drop  <= 1'b0;
      drop_hi   <= '0;
      drop_lo   <= '0;
    end else begin
      cls_valid <= in_valid;
      cls_low   <= in_valid && to_low;
      cls_drop  <= in_valid && !accept;
      if (in_valid && !accept) begin
        if (to_low && drop_lo != '1)  drop_lo <= drop_lo + 1'b1;
        if (!to_low && drop_hi != '1) drop_hi <= drop_hi + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sift_classifier_chk.sv
module sift_classifier_chk #(
  parameter int LFSR_W = 16,
  parameter int HI_CAP = 4,
  parameter int LO_CAP = 12,
  parameter int DROP_W = 16,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              strict_mode,
  input logic [LFSR_W:0]   coin_thresh,
  input logic              in_valid,
  input logic              cls_valid,
  input logic              cls_low,
  input logic              cls_drop,
  input logic              out_valid,
  input logic              out_lowprio,
  input logic [DROP_W-1:0] drop_hi,
  input logic [DROP_W-1:0] drop_lo,
  input logic [CW-1:0]     hi_cnt,
  input logic [CW-1:0]     lo_cnt,
  input logic              hit_any,
  input logic              hit_sampled
);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= CW'(HI_CAP) && lo_cnt <= CW'(LO_CAP));

  a_r9_drop_hi_count: assert property (@(posedge clk) disable iff (rst)
    (cls_valid && cls_drop && !cls_low) |->
      (drop_hi == $past(drop_hi) + 1'b1) || ($past(drop_hi) == '1));

  a_r9_drop_lo_count: assert property (@(posedge clk) disable iff (rst)
    (cls_valid && cls_drop && cls_low) |->
      (drop_lo == $past(drop_lo) + 1'b1) || ($past(drop_lo) == '1));

  a_r7_hi_first: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_lowprio) |-> hi_cnt == '0);

  a_r4_sampled_sticky: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit_sampled) |=> (cls_valid && cls_low));

  a_r2_zero_thresh_high: assert property (@(posedge clk) disable iff (rst)
    (in_valid && coin_thresh == '0 && !hit_sampled) |=> !cls_low);

  a_r5_first_head_high: assert property (@(posedge clk) disable iff (rst)
    (in_valid && strict_mode && !hit_any) |=> !cls_low);
endmodule

bind sift_classifier sift_classifier_chk #(
  .LFSR_W(LFSR_W), .HI_CAP(HI_CAP), .LO_CAP(LO_CAP), .DROP_W(DROP_W), .CW(CW)
) u_chk (.*);

// File: tb/tb_sift_classifier.sv
module tb_sift_classifier;
  localparam logic [16:0] FULL = 17'h10000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strict_mode = 1'b0;
  logic [16:0] coin_thresh = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_flow = '0;
  logic [7:0]  in_desc = '0;
  logic        out_ready = 1'b0;
  logic        cls_valid, cls_low, cls_drop, out_valid, out_lowprio;
  logic [15:0] out_flow, drop_hi, drop_lo;
  logic [7:0]  out_desc;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  sift_classifier dut (
    .clk(clk), .rst(rst), .strict_mode(strict_mode), .coin_thresh(coin_thresh),
    .in_valid(in_valid), .in_flow(in_flow), .in_desc(in_desc),
    .cls_valid(cls_valid), .cls_low(cls_low), .cls_drop(cls_drop),
    .out_ready(out_ready), .out_valid(out_valid), .out_lowprio(out_lowprio),
    .out_flow(out_flow), .out_desc(out_desc), .drop_hi(drop_hi), .drop_lo(drop_lo)
  );

  // {strict, all_heads, flow[15:0], expected_low}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0011, 1'b0},  // R2
    {1'b0, 1'b0, 16'h0011, 1'b0},  // R2
    {1'b0, 1'b1, 16'h0022, 1'b1},  // R3
    {1'b0, 1'b0, 16'h0022, 1'b1},  // R4
    {1'b0, 1'b0, 16'h0011, 1'b0},  // R2
    {1'b1, 1'b1, 16'h0033, 1'b0},  // R5 first head
    {1'b1, 1'b0, 16'h0033, 1'b0},  // R6 pending, tails
    {1'b1, 1'b1, 16'h0033, 1'b1},  // R5 second head
    {1'b1, 1'b0, 16'h0033, 1'b1},  // R4
    {1'b1, 1'b0, 16'h0022, 1'b1},  // R4
    {1'b0, 1'b0, 16'h0044, 1'b0}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; strict_mode = 1'b0; coin_thresh = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic [15:0] f, input logic [7:0] d, input logic full, input logic mode);
    @(negedge clk);
    in_valid = 1'b1; in_flow = f; in_desc = d; strict_mode = mode;
    coin_thresh = full ? FULL : '0;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(input string req, input logic [7:0] d, input logic low);
    @(negedge clk);
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {24'd0, out_desc}, {24'd0, d});
    check(req, {31'd0, out_lowprio}, {31'd0, low});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 drop_hi", {16'd0, drop_hi}, 32'd0);
    check("R1 drop_lo", {16'd0, drop_lo}, 32'd0);
    check("R1 cls_valid", {31'd0, cls_valid}, 32'd0);

    out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][16:1], 8'(i), VEC[i][17], VEC[i][18]);
      check($sformatf("vec%0d cls_low", i), {31'd0, cls_low}, {31'd0, VEC[i][0]});
      check($sformatf("vec%0d cls_drop R9", i), {31'd0, cls_drop}, 32'd0);
    end
    out_ready = 1'b0;

    do_reset();
    send(16'h0022, 8'h01, 1'b0, 1'b0);
    check("R1 table empty after reset", {31'd0, cls_low}, 32'd0);

    do_reset();
    send(16'h0050, 8'h01, 1'b1, 1'b0);
    send(16'h0050, 8'h02, 1'b0, 1'b0);
    send(16'h0060, 8'h03, 1'b0, 1'b0);
    send(16'h0061, 8'h04, 1'b0, 1'b0);
    pop("R7 hi first", 8'h03, 1'b0);
    pop("R8 hi order", 8'h04, 1'b0);
    pop("R8 lo order", 8'h01, 1'b1);
    pop("R8 lo order", 8'h02, 1'b1);
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);

    do_reset();
    for (int i = 0; i < 5; i++) begin
      send(16'h0070, 8'(8'h10 + i), 1'b0, 1'b0);
      check("R9 hi drop flag", {31'd0, cls_drop}, (i == 4) ? 32'd1 : 32'd0);
    end
    check("R9 drop_hi", {16'd0, drop_hi}, 32'd1);
    check("R9 drop_lo untouched", {16'd0, drop_lo}, 32'd0);
    for (int i = 0; i < 13; i++) begin
      send(16'h0080, 8'(8'h40 + i), 1'b1, 1'b0);
      check("R9 lo drop flag", {31'd0, cls_drop}, (i == 12) ? 32'd1 : 32'd0);
    end
    check("R9 drop_lo", {16'd0, drop_lo}, 32'd1);
    check("R9 drop_hi unchanged", {16'd0, drop_hi}, 32'd1);
    pop("R9 R7 hi kept", 8'h10, 1'b0);

    do_reset();
    out_ready = 1'b1;
    for (int i = 0; i < 9; i++) begin
      send(16'(16'h0100 + i), 8'(i), 1'b1, 1'b0);
      check("R10 fill sampled", {31'd0, cls_low}, 32'd1);
    end
    send(16'h0100, 8'h20, 1'b0, 1'b0);
    check("R10 evicted flow forgotten", {31'd0, cls_low}, 32'd0);
    send(16'h0101, 8'h21, 1'b0, 1'b0);
    check("R10 slot1 kept", {31'd0, cls_low}, 32'd1);
    send(16'h0108, 8'h22, 1'b0, 1'b0);
    check("R10 new flow recorded", {31'd0, cls_low}, 32'd1);
    out_ready = 1'b0;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule